// File: doc/BRIEF.md
# Posted MSI Coalescing Unit

This unit sits between device interrupt writes and a CPU's interrupt input. A write whose address lies in the message-signalled interrupt window is treated as an interrupt request. The low bits of its data word select an entry in a small remapping table, and that entry supplies a vector, a destination and a delivery mode. Writes outside the window are dropped silently.

An entry in remappable mode sends its translated vector straight out as an interrupt message. An entry in posted mode only sets the vector's bit in a 256-entry pending bitmap. If no notification is outstanding, the unit also sends one fixed notification vector and sets a busy flag. While that flag is up, further posted requests only add bits, so a burst of device vectors costs the CPU a single interrupt.

The consumer empties the bitmap with an exchange command. The command returns the old contents and leaves zeros behind. After the consumer has handled the vectors, it issues a re-arm command that clears the busy flag so that the next posted request raises a notification again.

Top module: `posted_msi_unit`

## Requirements
- R1: A write counts as a request only when `wr_addr[31:20]` equals 0xFEE. Any other write produces no message, no fault and no bitmap change.
- R2: The request selects table entry `wr_data[IDX_W-1:0]`. The entry's vector, destination and mode decide the outcome. A table write takes effect from the following cycle.
- R3: A request that hits an entry whose valid bit is clear produces a one-cycle `fault` pulse and nothing else.
- R4: A request that hits a valid remappable entry produces, one cycle later, `msg_valid`=1 with `msg_notify`=0, `msg_vec` equal to the entry vector and `msg_dest` equal to the entry destination.
- R5: A request that hits a valid posted entry sets bit `vector` of the pending bitmap. Any message it produces carries `NOTIFY_VEC` with `msg_notify`=1 and never carries the device vector.
- R6: A posted request sends a notification only when `notify_busy` is clear, and the notification sets `notify_busy`. While `notify_busy` is set, posted requests only set bitmap bits.
- R7: Raising `xchg_req` gives, one cycle later, `xchg_valid`=1 and `xchg_bits` equal to the bitmap before that edge, and the bitmap is left all zero. When `xchg_valid` is 0, `xchg_bits` is 0.
- R8: If a posted request and `xchg_req` occur in the same cycle, the request's bit is left in the cleared bitmap and is not part of the returned value.
- R9: `rearm` clears `notify_busy`. A posted request in the same cycle as `rearm` is notified, and `notify_busy` then stays set.
- R10: A posted request that arrives while `notify_busy` is clear is notified in the very next cycle, with no waiting for further requests.
- R11: A posted request whose vector bit is already set leaves the bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Device write strobe |
| wr_addr | input | 32 | Device write address |
| wr_data | input | 32 | Device write data; low bits index the table |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Entry to write |
| tbl_valid | input | 1 | Entry valid bit |
| tbl_posted | input | 1 | Entry mode: 1 posted, 0 remappable |
| tbl_vec | input | VEC_W | Entry vector |
| tbl_dest | input | DEST_W | Entry destination ID |
| xchg_req | input | 1 | Atomic read-and-clear of the pending bitmap |
| rearm | input | 1 | Clear the outstanding-notification flag |
| msg_valid | output | 1 | Interrupt message toward the CPU |
| msg_notify | output | 1 | Message is the posted notification |
| msg_vec | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| fault | output | 1 | Invalid-entry pulse |
| notify_busy | output | 1 | Notification outstanding |
| xchg_valid | output | 1 | Exchange result valid |
| xchg_bits | output | 2**VEC_W | Bitmap contents returned by the exchange |

## Verification
Every result is registered once, so a message, a fault pulse, an exchange result and a change of the busy flag all appear exactly one clock after the input that caused them. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs, and the outputs are compared with the model on the next falling edge, which is the one-cycle latency. The pending bitmap is hidden, so its state is observed through exchanges placed after the stimulus that could have touched it. The directed checks sample one falling edge after the write.

// File: rtl/posted_msi_unit.sv
module posted_msi_unit #(
  parameter int ENTRIES    = 16,
  parameter int VEC_W      = 8,
  parameter int DEST_W     = 8,
  parameter int NOTIFY_VEC = 8'hF2,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int NVEC      = 1 << VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [31:0]       wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic              tbl_valid,
  input  logic              tbl_posted,
  input  logic [VEC_W-1:0]  tbl_vec,
  input  logic [DEST_W-1:0] tbl_dest,
  input  logic              xchg_req,
  input  logic              rearm,
  output logic              msg_valid,
  output logic              msg_notify,
  output logic [VEC_W-1:0]  msg_vec,
  output logic [DEST_W-1:0] msg_dest,
  output logic              fault,
  output logic              notify_busy,
  output logic              xchg_valid,
  output logic [NVEC-1:0]   xchg_bits
);

  logic [ENTRIES-1:0] ent_valid, ent_posted;
  logic [VEC_W-1:0]   ent_vec  [ENTRIES];
  logic [DEST_W-1:0]  ent_dest [ENTRIES];
  logic [NVEC-1:0]    pending;

  wire              in_window = wr_valid && (wr_addr[31:20] == 12'hFEE);
  wire [IDX_W-1:0]  idx       = wr_data[IDX_W-1:0];
  wire              hit_ok    = in_window && ent_valid[idx];
  wire              hit_bad   = in_window && !ent_valid[idx];
  wire              do_post   = hit_ok && ent_posted[idx];
  wire              do_remap  = hit_ok && !ent_posted[idx];
  wire              busy_eff  = notify_busy && !rearm;
  wire              do_notify = do_post && !busy_eff;
  wire [NVEC-1:0]   new_bit   = do_post ? (NVEC'(1) << ent_vec[idx]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid  <= '0;
      ent_posted <= '0;
    end else if (tbl_we) begin
      ent_valid[tbl_idx]  <= tbl_valid;
      ent_posted[tbl_idx] <= tbl_posted;
    end
  end

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      ent_vec[tbl_idx]  <= tbl_vec;
      ent_dest[tbl_idx] <= tbl_dest;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending     <= '0;
      notify_busy <= 1'b0;
      msg_valid   <= 1'b0;
      msg_notify  <= 1'b0;
      msg_vec     <= '0;
      msg_dest    <= '0;
      fault       <= 1'b0;
      xchg_valid  <= 1'b0;
      xchg_bits   <= '0;
    end else begin
      pending     <= (xchg_req ? '0 : pending) | new_bit;
      notify_busy <= do_notify || busy_eff;
      msg_valid   <= do_remap || do_notify;
      msg_notify  <= do_notify;
      msg_vec     <= do_remap ? ent_vec[idx] : (do_notify ? VEC_W'(NOTIFY_VEC) : '0);
      msg_dest    <= (do_remap || do_notify) ? ent_dest[idx] : '0;
      fault       <= hit_bad;
      xchg_valid  <= xchg_req;
      xchg_bits   <= xchg_req ? pending : '0;
    end
  end

  AST_WINDOW_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid && wr_addr[31:20] != 12'hFEE) |-> !msg_valid && !fault); // R1
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !msg_valid); // R3
  AST_NOTIFY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_notify |-> msg_vec == VEC_W'(NOTIFY_VEC) && notify_busy); // R5
  AST_ONE_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_notify |-> !$past(notify_busy) || $past(rearm)); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    notify_busy && !rearm |=> notify_busy); // R9
  AST_XCHG_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_valid |-> $past(xchg_req)); // R7
  AST_XCHG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_valid |-> xchg_bits == '0); // R7

endmodule

// File: tb/tb_posted_msi_unit.sv
module tb_posted_msi_unit;
  localparam int NV = 256;
  localparam logic [7:0] NVEC_ID = 8'hF2;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, tbl_we = 0, tbl_valid = 0, tbl_posted = 0, xchg_req = 0, rearm = 0;
  logic [31:0] wr_addr = 0, wr_data = 0;
  logic [3:0] tbl_idx = 0;
  logic [7:0] tbl_vec = 0, tbl_dest = 0;
  logic msg_valid, msg_notify, fault, notify_busy, xchg_valid;
  logic [7:0] msg_vec, msg_dest;
  logic [NV-1:0] xchg_bits;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  posted_msi_unit dut (.*);

  task automatic check(input bit ok, input string tag, input logic [NV-1:0] act, input logic [NV-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_valid[16], m_posted[16];
  int m_vec[16], m_dest[16];
  logic [NV-1:0] e_pend = 0, e_xbits = 0;
  bit e_busy = 0, e_mv = 0, e_mn = 0, e_fault = 0, e_xv = 0;
  int e_mvec = 0, e_mdest = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_valid[i]) begin m_valid[i] = 0; m_posted[i] = 0; end
      e_pend = 0; e_xbits = 0; e_busy = 0; e_mv = 0; e_mn = 0; e_fault = 0; e_xv = 0;
      e_mvec = 0; e_mdest = 0;
    end else begin
      logic [NV-1:0] nb;
      bit busy_now, notified;
      int ix;
      nb = 0; notified = 0;
      busy_now = e_busy && !rearm;
      e_mv = 0; e_mn = 0; e_mvec = 0; e_mdest = 0; e_fault = 0;
      e_xv = xchg_req;
      e_xbits = xchg_req ? e_pend : '0;
      if (wr_valid && wr_addr[31:20] == 12'hFEE) begin
        ix = int'(wr_data[3:0]);
        if (!m_valid[ix]) e_fault = 1;
        else if (!m_posted[ix]) begin
          e_mv = 1; e_mvec = m_vec[ix]; e_mdest = m_dest[ix];
        end else begin
          nb[m_vec[ix]] = 1'b1;
          if (!busy_now) begin
            notified = 1; e_mv = 1; e_mn = 1; e_mvec = NVEC_ID; e_mdest = m_dest[ix];
          end
        end
      end
      e_pend = (xchg_req ? '0 : e_pend) | nb;
      e_busy = notified || busy_now;
      if (tbl_we) begin
        m_valid[tbl_idx] = tbl_valid; m_posted[tbl_idx] = tbl_posted;
        m_vec[tbl_idx] = tbl_vec; m_dest[tbl_idx] = tbl_dest;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(msg_valid == e_mv && msg_notify == e_mn, "R4 R5 R6 R10 msg", {msg_valid, msg_notify}, {e_mv, e_mn});
    check(msg_vec == e_mvec[7:0] && msg_dest == e_mdest[7:0], "R2 R4 R5 vec/dest",
          {msg_vec, msg_dest}, {e_mvec[7:0], e_mdest[7:0]});
    check(fault == e_fault, "R3 fault", fault, e_fault);
    check(notify_busy == e_busy, "R6 R9 busy", notify_busy, e_busy);
    check(xchg_valid == e_xv && xchg_bits == e_xbits, "R7 R8 xchg", xchg_bits, e_xbits);
  end

  task automatic prog(input int i, input bit v, input bit p, input int vec, input int d);
    @(negedge clk);
    tbl_we = 1; tbl_idx = i[3:0]; tbl_valid = v; tbl_posted = p; tbl_vec = vec[7:0]; tbl_dest = d[7:0];
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic cyc(input bit w, input logic [31:0] a, input int i, input bit x, input bit r);
    @(negedge clk);
    wr_valid = w; wr_addr = a; wr_data = i; xchg_req = x; rearm = r;
    @(negedge clk);
    wr_valid = 0; xchg_req = 0; rearm = 0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!msg_valid && !fault && !notify_busy && !xchg_valid, "R6 reset state", {msg_valid, fault, notify_busy, xchg_valid}, 0);
    rst_n = 1;
    prog(1, 1, 0, 8'h33, 5);
    prog(2, 1, 1, 8'h41, 2);
    prog(3, 1, 1, 8'hFF, 7);
    prog(4, 1, 1, 8'h00, 1);
    cyc(1, 32'hFED0_0000, 1, 0, 0);
    check(!msg_valid && !fault, "R1 out of window", {msg_valid, fault}, 0);
    cyc(1, 32'hFEE0_1000, 1, 0, 0);
    check(msg_valid && !msg_notify && msg_vec == 8'h33 && msg_dest == 8'd5, "R2 R4 remap", {msg_vec, msg_dest}, {8'h33, 8'd5});
    cyc(1, 32'hFEE0_0000, 0, 0, 0);
    check(fault && !msg_valid, "R3 invalid entry", {fault, msg_valid}, 2'b10);
    cyc(1, 32'hFEE0_0000, 2, 0, 0);
    check(msg_valid && msg_notify && msg_vec == NVEC_ID, "R5 R10 notify", msg_vec, NVEC_ID);
    cyc(1, 32'hFEE0_0000, 3, 0, 0);
    check(!msg_valid && notify_busy, "R6 suppressed", msg_valid, 0);
    cyc(1, 32'hFEE0_0000, 2, 0, 0);
    cyc(0, 0, 0, 1, 0);
    check(xchg_valid && $countones(xchg_bits) == 2 && xchg_bits[8'h41] && xchg_bits[8'hFF], "R7 R11 exchange", xchg_bits, 0);
    cyc(1, 32'hFEE0_0000, 4, 1, 0);
    check(xchg_valid && xchg_bits == 0, "R8 same-cycle return", xchg_bits, 0);
    cyc(0, 0, 0, 1, 0);
    check(xchg_bits == NV'(1), "R8 bit kept", xchg_bits, NV'(1));
    cyc(0, 0, 0, 0, 1);
    check(!notify_busy, "R9 rearm", notify_busy, 0);
    cyc(1, 32'hFEE0_0000, 3, 0, 0);
    check(msg_valid && msg_notify, "R10 lone request", msg_valid, 1);
    cyc(1, 32'hFEE0_0000, 2, 0, 1);
    check(msg_valid && msg_notify && notify_busy, "R9 rearm with request", {msg_valid, notify_busy}, 2'b11);
    prog(2, 0, 1, 8'h41, 2);
    cyc(1, 32'hFEE0_0000, 2, 0, 0);
    check(fault, "R2 table update", fault, 1);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      wr_valid = $urandom_range(0, 1);
      wr_addr = ($urandom_range(0, 3) != 0) ? 32'hFEE0_0000 | $urandom_range(0, 4095) : $urandom;
      wr_data = $urandom_range(0, 15);
      xchg_req = ($urandom_range(0, 5) == 0);
      rearm = ($urandom_range(0, 7) == 0);
      tbl_we = ($urandom_range(0, 9) == 0);
      tbl_idx = $urandom_range(0, 15); tbl_valid = $urandom_range(0, 3) != 0;
      tbl_posted = $urandom_range(0, 1); tbl_vec = $urandom; tbl_dest = $urandom;
    end
    @(negedge clk);
    wr_valid = 0; xchg_req = 0; rearm = 0; tbl_we = 0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule